// File: doc/BRIEF.md
# Zero-Cross-Gated Digital Volume Attenuator

This block scales six signed audio channels, grouped as three stereo pairs, by a per-channel attenuation level. Each channel owns an 8-bit level code. Code 0xFF is unity gain. Each step down in code adds 0.5 dB of attenuation. Code 0x00 silences the channel completely. A single write to the master address loads the same code into all six channels. The gain for a code is built from a twelve-entry mantissa table that spans one 6 dB octave, followed by an arithmetic right shift of the scaled product.

A register write never changes the gain at once. The new code waits in a per-channel pending slot. It moves to the active slot only when that channel's own signal passes through zero. This avoids an audible step in a large waveform. A zero-cross disable input skips the wait, and a pending code then takes effect on the channel's next valid sample. The output valid strobe follows the input strobe two clock cycles later.

Top module: `zc_vol_atten`

## Requirements
- R1: After reset every channel has active code 0xFF and no pending update, and `samp_vld_o` and `samp_o` are zero. A valid sample then leaves the block unchanged.
- R2: A sample processed with active code 0x00 produces an output of exactly zero.
- R3: For a code c from 1 to 255, let a = 255 - c, q = a / 12, r = a mod 12 and m = round(32768 * 10^(-r/40)). The output is floor((x*m + 2^(14+q)) / 2^(15+q)), kept at 24 bits signed.
- R4: For each channel, `samp_vld_o` is high exactly two cycles after `samp_vld_i` was high. While a channel has no valid output, its `samp_o` holds its last value.
- R5: A write with `wr_addr_i` from 0 to 5 loads the pending code of that channel only. A write to address 6 loads all six channels. Writes to addresses 7 to 15 have no effect.
- R6: With `zc_dis_i` low, a pending code becomes active only on a valid sample that is zero, or whose sign bit differs from that of the channel's previous valid sample. The sign of the previous sample counts as non-negative after reset. The new gain already applies to that triggering sample.
- R7: A crossing on one channel never activates the pending code of another channel.
- R8: A second write to a channel before its crossing replaces the earlier pending code. Only the latest code becomes active.
- R9: With `zc_dis_i` high, a pending code becomes active on the channel's next valid sample, whatever its sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Level write strobe |
| wr_addr_i | input | 4 | Write address: 0-5 channel, 6 all channels |
| wr_data_i | input | 8 | Attenuation code |
| zc_dis_i | input | 1 | 1 applies pending codes without waiting for a crossing |
| samp_i | input | 6x24 | Signed input sample per channel |
| samp_vld_i | input | 6 | Input valid per channel |
| samp_o | output | 6x24 | Attenuated signed sample per channel |
| samp_vld_o | output | 6 | Output valid per channel |

## Verification
The hardest state to reach from the ports is a channel that holds a pending code while other channels cross zero, gain new codes, or see the same pending code replaced. The stimulus leaves one channel's sign unchanged over several samples while writes and sign flips land on other channels. It then drives a negative or zero sample on the waiting channel and checks that the latest code applies to exactly that sample. Every code from 0x00 to 0xFF is swept through the master address, with gating disabled, against full-scale, unit and mid-range samples of both signs. A long pseudo-random phase then mixes writes to all sixteen addresses, toggling of the disable input, and partial valid masks.

// File: rtl/zc_vol_pkg.sv
package zc_vol_pkg;
  localparam int ATT_W     = 8;
  localparam int MANT_W    = 16;
  localparam int MANT_FRAC = 15;
  localparam int SHIFT_W   = 5;
  localparam int OCT_STEPS = 12;

  typedef logic [ATT_W-1:0] att_code_t;

  localparam att_code_t CODE_UNITY = 8'hFF;
  localparam att_code_t CODE_MUTE  = 8'h00;

  // 32768 * 10^(-k/40), k = half-dB step within one octave
  function automatic logic [MANT_W-1:0] mant_lut(input logic [3:0] idx);
    case (idx)
      4'd0:    return 16'd32768;
      4'd1:    return 16'd30935;
      4'd2:    return 16'd29205;
      4'd3:    return 16'd27571;
      4'd4:    return 16'd26029;
      4'd5:    return 16'd24573;
      4'd6:    return 16'd23198;
      4'd7:    return 16'd21900;
      4'd8:    return 16'd20675;
      4'd9:    return 16'd19519;
      4'd10:   return 16'd18427;
      4'd11:   return 16'd17396;
      default: return 16'd0;
    endcase
  endfunction
endpackage

// File: rtl/zc_vol_gain_dec.sv
module zc_vol_gain_dec
  import zc_vol_pkg::*;
(
  input  att_code_t          code_i,
  output logic               mute_o,
  output logic [MANT_W-1:0]  mant_o,
  output logic [SHIFT_W-1:0] shift_o
);
  logic [ATT_W-1:0] att, oct, step;
  logic unused_dec_hi;

  always_comb begin
    att     = CODE_UNITY - code_i;
    oct     = att / ATT_W'(OCT_STEPS);
    step    = att % ATT_W'(OCT_STEPS);
    mute_o  = (code_i == CODE_MUTE);
    mant_o  = mant_lut(step[3:0]);
    shift_o = oct[SHIFT_W-1:0];
  end

  assign unused_dec_hi = ^{oct[ATT_W-1:SHIFT_W], step[ATT_W-1:4]};
endmodule

// File: rtl/zc_vol_scale.sv
module zc_vol_scale
  import zc_vol_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     vld_i,
  input  logic signed [DATA_W-1:0] samp_i,
  input  att_code_t                code_i,
  output logic signed [DATA_W-1:0] samp_o,
  output logic                     vld_o
);
  localparam int PROD_W = DATA_W + MANT_W + 2;
  localparam int SH_W   = SHIFT_W + 1;

  logic               mute;
  logic [MANT_W-1:0]  mant;
  logic [SHIFT_W-1:0] shift;
  logic [SH_W-1:0]    rsh;
  logic signed [PROD_W-1:0] prod, rnd, acc, scaled;
  logic unused_scaled_hi;

  zc_vol_gain_dec i_dec (
    .code_i  (code_i),
    .mute_o  (mute),
    .mant_o  (mant),
    .shift_o (shift)
  );

  always_comb begin
    rsh    = SH_W'(MANT_FRAC) + SH_W'(shift);
    prod   = PROD_W'(samp_i) * $signed(PROD_W'({1'b0, mant}));
    rnd    = PROD_W'(1) <<< (rsh - SH_W'(1));
    acc    = prod + rnd;
    scaled = acc >>> rsh;
  end

  assign unused_scaled_hi = ^scaled[PROD_W-1:DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      samp_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) samp_o <= mute ? '0 : scaled[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/zc_vol_chan.sv
module zc_vol_chan
  import zc_vol_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int ADDR_W      = 4,
  parameter int CH_IDX      = 0,
  parameter int MASTER_ADDR = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  att_code_t         wr_data_i,
  input  logic              zc_dis_i,
  input  logic [DATA_W-1:0] samp_i,
  input  logic              samp_vld_i,
  output logic [DATA_W-1:0] s1_samp_o,
  output att_code_t         s1_code_o,
  output logic              s1_vld_o,
  output att_code_t         act_code_o,
  output att_code_t         pend_code_o,
  output logic              pend_vld_o
);
  logic      hit, zc, apply, prev_sign_q;
  att_code_t eff_code;

  always_comb begin
    hit      = wr_en_i && (wr_addr_i == ADDR_W'(CH_IDX) || wr_addr_i == ADDR_W'(MASTER_ADDR));
    zc       = (samp_i[DATA_W-1] != prev_sign_q) || (samp_i == '0);
    apply    = samp_vld_i && pend_vld_o && (zc || zc_dis_i);
    eff_code = apply ? pend_code_o : act_code_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_code_o  <= CODE_UNITY;
      pend_code_o <= CODE_UNITY;
      pend_vld_o  <= 1'b0;
      prev_sign_q <= 1'b0;
      s1_samp_o   <= '0;
      s1_code_o   <= CODE_UNITY;
      s1_vld_o    <= 1'b0;
    end else begin
      s1_vld_o <= samp_vld_i;
      if (hit) pend_code_o <= wr_data_i;
      // a write in the apply cycle keeps the newer code pending
      if (hit)        pend_vld_o <= 1'b1;
      else if (apply) pend_vld_o <= 1'b0;
      if (samp_vld_i) begin
        act_code_o  <= eff_code;
        prev_sign_q <= samp_i[DATA_W-1];
        s1_samp_o   <= samp_i;
        s1_code_o   <= eff_code;
      end
    end
  end
endmodule

// File: rtl/zc_vol_atten.sv
module zc_vol_atten
  import zc_vol_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 24,
  parameter int ADDR_W = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [ATT_W-1:0]               wr_data_i,
  input  logic                           zc_dis_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  samp_i,
  input  logic [NUM_CH-1:0]              samp_vld_i,
  output logic [NUM_CH-1:0][DATA_W-1:0]  samp_o,
  output logic [NUM_CH-1:0]              samp_vld_o
);
  localparam int MASTER_ADDR = NUM_CH;

  logic [NUM_CH-1:0][DATA_W-1:0] s1_samp;
  logic [NUM_CH-1:0][ATT_W-1:0]  s1_code, act_code, pend_code;
  logic [NUM_CH-1:0]             s1_vld, pend_vld;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    zc_vol_chan #(
      .DATA_W      (DATA_W),
      .ADDR_W      (ADDR_W),
      .CH_IDX      (g),
      .MASTER_ADDR (MASTER_ADDR)
    ) i_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_en_i     (wr_en_i),
      .wr_addr_i   (wr_addr_i),
      .wr_data_i   (wr_data_i),
      .zc_dis_i    (zc_dis_i),
      .samp_i      (samp_i[g]),
      .samp_vld_i  (samp_vld_i[g]),
      .s1_samp_o   (s1_samp[g]),
      .s1_code_o   (s1_code[g]),
      .s1_vld_o    (s1_vld[g]),
      .act_code_o  (act_code[g]),
      .pend_code_o (pend_code[g]),
      .pend_vld_o  (pend_vld[g])
    );

    zc_vol_scale #(.DATA_W(DATA_W)) i_scale (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (s1_vld[g]),
      .samp_i (s1_samp[g]),
      .code_i (s1_code[g]),
      .samp_o (samp_o[g]),
      .vld_o  (samp_vld_o[g])
    );
  end
endmodule

// File: rtl/zc_vol_atten_chk.sv
module zc_vol_atten_chk #(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 24
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          zc_dis_i,
  input logic [NUM_CH-1:0][DATA_W-1:0] samp_i,
  input logic [NUM_CH-1:0]             samp_vld_i,
  input logic [NUM_CH-1:0][DATA_W-1:0] samp_o,
  input logic [NUM_CH-1:0]             samp_vld_o,
  input logic [NUM_CH-1:0][DATA_W-1:0] s1_samp,
  input logic [NUM_CH-1:0][7:0]        s1_code,
  input logic [NUM_CH-1:0]             s1_vld,
  input logic [NUM_CH-1:0][7:0]        act_code,
  input logic [NUM_CH-1:0][7:0]        pend_code,
  input logic [NUM_CH-1:0]             pend_vld
);
  logic [1:0]        warm_q;
  logic [NUM_CH-1:0] sign_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warm_q <= '0;
      sign_q <= '0;
    end else begin
      if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
      for (int c = 0; c < NUM_CH; c++)
        if (samp_vld_i[c]) sign_q[c] <= samp_i[c][DATA_W-1];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    p_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q == 2'd2) |-> (samp_vld_o[c] == $past(samp_vld_i[c], 2)));

    p_out_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !s1_vld[c] |=> $stable(samp_o[c]));

    p_mute_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s1_vld[c] && s1_code[c] == 8'h00) |=> (samp_o[c] == '0));

    p_unity_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s1_vld[c] && s1_code[c] == 8'hFF) |=> (samp_o[c] == $past(s1_samp[c])));

    p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !samp_vld_i[c] |=> $stable(act_code[c]));

    p_no_cross_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (samp_vld_i[c] && !zc_dis_i && samp_i[c] != '0 && samp_i[c][DATA_W-1] == sign_q[c])
      |=> $stable(act_code[c]));

    p_dis_apply_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (samp_vld_i[c] && zc_dis_i && pend_vld[c]) |=> (act_code[c] == $past(pend_code[c])));
  end
endmodule

bind zc_vol_atten zc_vol_atten_chk #(
  .NUM_CH (NUM_CH),
  .DATA_W (DATA_W)
) i_zc_vol_atten_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .zc_dis_i   (zc_dis_i),
  .samp_i     (samp_i),
  .samp_vld_i (samp_vld_i),
  .samp_o     (samp_o),
  .samp_vld_o (samp_vld_o),
  .s1_samp    (s1_samp),
  .s1_code    (s1_code),
  .s1_vld     (s1_vld),
  .act_code   (act_code),
  .pend_code  (pend_code),
  .pend_vld   (pend_vld)
);

// File: tb/test_zc_vol_atten.sv
`timescale 1ns/1ps
module test_zc_vol_atten;
  localparam int NC = 6;
  localparam int DW = 24;
  localparam int AW = 4;

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic                  wr_en_i = 1'b0;
  logic [AW-1:0]         wr_addr_i = '0;
  logic [7:0]            wr_data_i = '0;
  logic                  zc_dis_i = 1'b0;
  logic [NC-1:0][DW-1:0] samp_i = '0;
  logic [NC-1:0]         samp_vld_i = '0;
  logic [NC-1:0][DW-1:0] samp_o;
  logic [NC-1:0]         samp_vld_o;

  always #4 clk_i = ~clk_i;

  zc_vol_atten #(.NUM_CH(NC), .DATA_W(DW), .ADDR_W(AW)) i_zc_vol_atten (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .zc_dis_i,
    .samp_i, .samp_vld_i, .samp_o, .samp_vld_o
  );

  int n_chk = 0;
  int n_fail = 0;

  int                    act_m [NC];
  int                    pend_m[NC];
  bit                    pv_m  [NC];
  bit                    neg_m [NC];
  logic signed [DW-1:0]  out_m [NC];
  logic signed [DW-1:0]  stim  [NC];

  function automatic int mant_of(int r);
    real v;
    v = 32768.0 * (10.0 ** (-r / 40.0));
    return int'($floor(v + 0.5));
  endfunction

  function automatic logic signed [DW-1:0] expect_out(logic signed [DW-1:0] x, int code);
    int a, q, r;
    longint p;
    if (code == 0) return '0;
    a = 255 - code;
    q = a / 12;
    r = a % 12;
    p = longint'(x) * longint'(mant_of(r)) + (longint'(1) <<< (14 + q));
    p = p >>> (15 + q);
    return DW'(p);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = AW'(a); wr_data_i = 8'(d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    for (int c = 0; c < NC; c++)
      if (a == c || a == NC) begin pend_m[c] = d; pv_m[c] = 1'b1; end
  endtask

  task automatic send(bit [NC-1:0] m, string req);
    @(negedge clk_i);
    for (int c = 0; c < NC; c++) begin
      samp_i[c] = stim[c];
      if (m[c]) begin
        bit zc;
        zc = (stim[c][DW-1] != neg_m[c]) || (stim[c] == '0);
        if (pv_m[c] && (zc || zc_dis_i)) begin act_m[c] = pend_m[c]; pv_m[c] = 1'b0; end
        neg_m[c] = stim[c][DW-1];
        out_m[c] = expect_out(stim[c], act_m[c]);
      end
    end
    samp_vld_i = m;
    @(negedge clk_i);
    samp_vld_i = '0;
    chk(samp_vld_o == '0, "R4 early valid", longint'(samp_vld_o), 0);
    @(negedge clk_i);
    chk(samp_vld_o == m, "R4 valid", longint'(samp_vld_o), longint'(m));
    for (int c = 0; c < NC; c++)
      chk($signed(samp_o[c]) == out_m[c], req, longint'($signed(samp_o[c])), longint'(out_m[c]));
  endtask

  task automatic set_all(logic signed [DW-1:0] v);
    for (int c = 0; c < NC; c++) stim[c] = v;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) begin
      act_m[c] = 255; pend_m[c] = 255; pv_m[c] = 1'b0; neg_m[c] = 1'b0; out_m[c] = '0; stim[c] = '0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(samp_vld_o == '0, "R1 reset valid", longint'(samp_vld_o), 0);
    chk(samp_o == '0, "R1 reset data", 1, 0);
    for (int c = 0; c < NC; c++) stim[c] = DW'(1000 * (c + 1) + 7);
    send('1, "R1 unity after reset");

    // R2/R3 exhaustive code sweep, gating off
    zc_dis_i = 1'b1;
    for (int code = 255; code >= 0; code--) begin
      wr(NC, code);
      stim[0] = 24'sh7FFFFF;
      stim[1] = -24'sh800000;
      stim[2] = 24'sd1;
      stim[3] = -24'sd1;
      stim[4] = DW'(code * 32771);
      stim[5] = DW'(-(code * 12345 + 7));
      send('1, code == 0 ? "R2 mute" : "R3 gain");
    end

    // R9 gating off applies on next sample, no sign change needed
    wr(NC, 255); set_all(24'sd50000); send('1, "R9 restore");
    wr(4, 8'h10); set_all(24'sd60000); send('1, "R9 immediate");

    // R5 address decode
    wr(9, 0);  set_all(24'sd70000); send('1, "R5 ignored addr");
    wr(15, 0); set_all(24'sd71000); send('1, "R5 ignored addr");
    wr(3, 8'h20); set_all(24'sd72000); send('1, "R5 single channel");
    wr(NC, 255); set_all(24'sd73000); send('1, "R5 master");

    // R6/R7/R8 zero-cross gating
    zc_dis_i = 1'b0;
    set_all(24'sd80000); send('1, "R6 baseline");
    wr(2, 8'h80);
    set_all(24'sd81000); send('1, "R6 held without crossing");
    wr(2, 8'h40);
    wr(5, 8'h90);
    set_all(24'sd82000); stim[0] = -24'sd82000;
    send('1, "R7 other channel crossing");
    set_all(24'sd83000); stim[0] = -24'sd83000; stim[2] = -24'sd83000;
    send('1, "R8 latest code applied at crossing");
    set_all(24'sd84000); stim[0] = -24'sd84000; stim[2] = -24'sd84000; stim[5] = '0;
    send('1, "R6 zero sample crossing");
    set_all(24'sd85000); stim[0] = -24'sd85000; stim[2] = -24'sd85000;
    send('1, "R6 new gain held");
    wr(1, 8'hC0);
    set_all(24'sd86000); send(6'b111101, "R6 channel idle");
    stim[1] = -24'sd86000; send(6'b000010, "R6 crossing on negative step");

    // pseudo-random mix
    for (int it = 0; it < 600; it++) begin
      bit [NC-1:0] m;
      if ($urandom_range(0, 2) == 0) wr(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)));
      if ($urandom_range(0, 7) == 0) zc_dis_i = ~zc_dis_i;
      for (int c = 0; c < NC; c++) begin
        if ($urandom_range(0, 9) == 0) stim[c] = '0;
        else stim[c] = DW'($urandom);
      end
      m = NC'($urandom);
      send(m, zc_dis_i ? "R9 random" : "R6 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule